// File: doc/BRIEF.md
# Masked-Address GPIO Port Controller

This block controls one port of eight general-purpose pins from a simple memory-mapped register bus. Software sets each pin's direction and enable bit. It reads and drives pin values through a data window. In that window the word address itself acts as a bit mask: address bit n+2 selects data bit n. One bus access can therefore set, clear or sample any subset of pins, with no read-modify-write sequence and no race against other users of the same port.

Pins leave the block as three vectors: the output value, the output enable and the raw input. Every pin input passes through a two-stage synchroniser. The synchronised value is used for data reads and is also offered on a separate port to the interrupt block that sits beside this one. Reads are registered, so read data appears on the cycle after the read strobe.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, the output latch, the direction register, the enable register, `pin_out`, `pin_oe` and `bus_rdata` are all zero.
- R2: Any offset with address bits [11:10] equal to 0 is the data window (0x000 to 0x3FC). A write there changes bit n of the output latch only when address bit n+2 is 1. That bit then takes `bus_wdata[n]`, and every other latch bit keeps its value. Address bits [1:0] take no part in decoding, for any register.
- R3: A data-window read returns 0 in every bit position n whose address bit n+2 is 0.
- R4: A data-window read returns, for each selected bit n, the output latch bit when direction bit n is 1, and the synchronised input bit when it is 0.
- R5: A data-window write stores the selected bits even for pins whose direction bit is 0. `pin_out` always shows the latch, so the stored value is driven once the pin is switched to output.
- R6: Offset 0x400 is the direction register: it reads back what was written, and bit value 1 means output.
- R7: Offset 0x420 is the enable register: it reads back what was written, and bit value 1 means enabled.
- R8: `pin_oe[n]` is 1 exactly when direction bit n and enable bit n are both 1, from the cycle after the write that sets them.
- R9: `pin_in_sync` follows `pin_in` two clock edges later, and data reads use this delayed value.
- R10: A read at any other offset returns 0, and a write there changes no register and no pin.
- R11: `bus_rdata` carries the read value in the cycle after `bus_rd` is sampled high, and is 0 in a cycle after `bus_rd` was low.
- R12: When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin input levels |
| pin_out | output | 8 | Output latch, driven to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_in_sync | output | 8 | Synchronised pin inputs for neighbouring logic |

## Verification
A wrong latch bit shows up on `pin_out` on the very next cycle after the write. So every masked write is compared against an arithmetic model at once, over all 256 masks. A wrong direction or enable bit shows up on `pin_oe` in the same cycle, and it also changes which source a data read returns. The read sweeps therefore mix output and input pins under every mask. A synchroniser with the wrong depth moves `pin_in_sync` by a cycle, which a check one edge after an input change and one edge after that will catch.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    // Register targeted by the current bus address
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DATA = 2'd1,
        TGT_DIR  = 2'd2,
        TGT_EN   = 2'd3
    } gpio_tgt_e;

endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
    import gpio_mp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned DIR_OFS  = 32'h400,
    parameter int unsigned EN_OFS   = 32'h420
) (
    input  logic [ADDR_W-1:2]   word_addr,
    output gpio_tgt_e           tgt,
    output logic [NUM_PINS-1:0] mask
);
    localparam int unsigned MASK_HI = NUM_PINS + 1;
    localparam int unsigned WIN_LO  = NUM_PINS + 2;
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_OFS);

    logic in_window;

    assign in_window = (word_addr[ADDR_W-1:WIN_LO] == '0);
    assign mask      = word_addr[MASK_HI:2];

    always_comb begin
        if (in_window)                          tgt = TGT_DATA;
        else if (word_addr == DIR_A[ADDR_W-1:2]) tgt = TGT_DIR;
        else if (word_addr == EN_A[ADDR_W-1:2])  tgt = TGT_EN;
        else                                     tgt = TGT_NONE;
    end
endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
    import gpio_mp_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  gpio_tgt_e           tgt,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] en_q
);
    typedef struct packed {
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] en;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (tgt)
                TGT_DATA: st_d.latch = (st_q.latch & ~mask) | (wdata & mask);
                TGT_DIR:  st_d.dir   = wdata;
                TGT_EN:   st_d.en    = wdata;
                default:  st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_q = st_q.latch;
    assign dir_q = st_q.dir;
    assign en_q  = st_q.en;
endmodule

// File: rtl/gpio_mp_rdmux.sv
module gpio_mp_rdmux
    import gpio_mp_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  gpio_tgt_e           tgt,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] out_q,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] en_q,
    input  logic [NUM_PINS-1:0] sync_in,
    output logic [NUM_PINS-1:0] rd_value
);
    logic [NUM_PINS-1:0] window_val;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
        assign window_val[n] = mask[n] & (dir_q[n] ? out_q[n] : sync_in[n]);
    end

    always_comb begin
        case (tgt)
            TGT_DATA: rd_value = window_val;
            TGT_DIR:  rd_value = dir_q;
            TGT_EN:   rd_value = en_q;
            default:  rd_value = '0;
        endcase
    end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_mp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIR_OFS     = 32'h400,
    parameter int unsigned EN_OFS      = 32'h420
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_in_sync
);
    gpio_tgt_e           tgt;
    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] out_q, dir_q, en_q;
    logic [NUM_PINS-1:0] sync_in;
    logic [NUM_PINS-1:0] rd_value;
    logic [NUM_PINS-1:0] rdata_d, rdata_q;
    logic                unused_lsb;

    assign unused_lsb = ^bus_addr[1:0];

    gpio_mp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_in)
    );

    gpio_mp_decode #(
        .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .DIR_OFS(DIR_OFS), .EN_OFS(EN_OFS)
    ) u_decode (
        .word_addr(bus_addr[ADDR_W-1:2]),
        .tgt      (tgt),
        .mask     (mask)
    );

    gpio_mp_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (bus_wr),
        .tgt  (tgt),
        .mask (mask),
        .wdata(bus_wdata),
        .out_q(out_q),
        .dir_q(dir_q),
        .en_q (en_q)
    );

    gpio_mp_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
        .tgt     (tgt),
        .mask    (mask),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .en_q    (en_q),
        .sync_in (sync_in),
        .rd_value(rd_value)
    );

    always_comb begin
        rdata_d = bus_rd ? rd_value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata   = rdata_q;
    assign pin_out     = out_q;
    assign pin_oe      = dir_q & en_q;
    assign pin_in_sync = sync_in;
endmodule

// File: rtl/gpio_mp_checker.sv
module gpio_mp_checker #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned DIR_OFS  = 32'h400,
    parameter int unsigned EN_OFS   = 32'h420
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_in_sync
);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_OFS);

    logic                win, hit_dir, hit_en;
    logic [NUM_PINS-1:0] amask;
    logic [1:0]          age_q;

    assign win     = (bus_addr[ADDR_W-1:NUM_PINS+2] == '0);
    assign hit_dir = (bus_addr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
    assign hit_en  = (bus_addr[ADDR_W-1:2] == EN_A[ADDR_W-1:2]);
    assign amask   = bus_addr[NUM_PINS+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

    assert_masked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win) |=> (((pin_out ^ $past(pin_out)) & ~$past(amask)) == '0));

    assert_masked_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win) |=> ((pin_out & $past(amask)) == ($past(bus_wdata) & $past(amask))));

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || !win) |=> $stable(pin_out));

    assert_read_maskoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && win) |=> ((bus_rdata & ~$past(amask)) == '0));

    assert_undecoded_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !win && !hit_dir && !hit_en) |=> (bus_rdata == '0));

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (hit_dir || hit_en)) |=> $stable(pin_oe));

    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pin_in_sync == $past(pin_in, 2)));
endmodule

bind gpio_masked_port gpio_mp_checker #(
    .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .DIR_OFS(DIR_OFS), .EN_OFS(EN_OFS)
) u_checker (.*);

// File: tb/tb_gpio_masked_port.sv
`timescale 1ns/1ps
module tb_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic [7:0]  pin_in = '0, pin_out, pin_oe, pin_in_sync;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [7:0] m_out = '0, m_dir = '0, m_en = '0;

    always #10 clk = ~clk;

    gpio_masked_port dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in_sync(pin_in_sync)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [11:0] a);
        int w = int'(a) / 4;
        if (w < 256) return 8'(w) & ((m_dir & m_out) | (~m_dir & pin_in));
        if (w == 256) return m_dir;
        if (w == 264) return m_en;
        return 8'h00;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [7:0] d);
        int w = int'(a) / 4;
        if (w < 256) m_out = (m_out & ~8'(w)) | (d & 8'(w));
        else if (w == 256) m_dir = d;
        else if (w == 264) m_en = d;
    endfunction

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};
        logic [11:0] bad [6] = '{12'h404, 12'h41C, 12'h424, 12'h800, 12'hFFC, 12'h7FC};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in the registers
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        do_read(12'h400, v); check("R1 dir", v, 8'h00);
        do_read(12'h420, v); check("R1 en", v, 8'h00);
        do_read(12'h3FC, v); check("R1 data", v, 8'h00);

        // R2/R5: masked writes over every mask, pins still inputs; low address bits vary
        for (int m = 0; m < 256; m++) begin
            for (int p = 0; p < 4; p++) begin
                do_write(12'(m * 4 + (m + p) % 4), pats[p] ^ 8'(m));
                check("R2 masked write", pin_out, m_out);
                check("R8 oe stays low", pin_oe, 8'h00);
            end
        end
        do_write(12'h004, 8'hFE);  // only bit 0 takes the 0
        check("R2 single bit", pin_out, m_out);

        // R5: stored while input, driven after switching to output
        do_write(12'h3FC, 8'h6C);
        do_write(12'h400, 8'hFF);
        do_write(12'h420, 8'hFF);
        check("R5 latch kept", pin_out, 8'h6C);
        check("R5 now driven", pin_oe, 8'hFF);

        // R6/R7/R8: register readback and output-enable combination
        for (int i = 0; i < 64; i++) begin
            do_write(12'h400, 8'(i * 37 + 5));
            do_write(12'h420 | 12'(i % 4), 8'(i * 91 + 3));
            do_read(12'h400, v); check("R6 dir readback", v, 8'(i * 37 + 5));
            do_read(12'h420, v); check("R7 en readback", v, 8'(i * 91 + 3));
            check("R8 oe", pin_oe, 8'(i * 37 + 5) & 8'(i * 91 + 3));
        end

        // R3/R4: read sweeps with mixed input/output pins
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            pin_in = (s == 0) ? 8'h3C : 8'hC3;
            repeat (3) @(negedge clk);
            do_write(12'h400, (s == 0) ? 8'hF0 : 8'h0F);
            do_write(12'h3FC, (s == 0) ? 8'h96 : 8'h69);
            for (int m = 0; m < 256; m++) begin
                do_read(12'(m * 4), v);
                check("R3/R4 masked read", v, model_read(12'(m * 4)));
            end
        end

        // R9: two-edge synchroniser, reads see the delayed value
        do_write(12'h400, 8'h00);
        @(negedge clk);
        pin_in = 8'h5A;
        @(negedge clk);
        check("R9 one edge", pin_in_sync, 8'hC3);
        @(negedge clk);
        check("R9 two edges", pin_in_sync, 8'h5A);
        do_read(12'h3FC, v); check("R9 read input", v, 8'h5A);

        // R10: undecoded offsets ignore writes and read as zero
        do_write(12'h400, 8'h33);
        do_write(12'h420, 8'h0F);
        do_write(12'h3FC, 8'hC5);
        foreach (bad[i]) begin
            do_write(bad[i], 8'hFF);
            check("R10 pin_out kept", pin_out, 8'hC5);
            check("R10 pin_oe kept", pin_oe, 8'h03);
            do_read(bad[i], v); check("R10 read zero", v, 8'h00);
        end
        do_read(12'h400, v); check("R10 dir kept", v, 8'h33);
        do_read(12'h420, v); check("R10 en kept", v, 8'h0F);

        // R11: data only follows a read strobe
        do_read(12'h400, v);
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 8'h00);

        // R12: read and write in the same cycle return the old value
        @(negedge clk);
        bus_addr = 12'h400; bus_wdata = 8'hA1; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R12 old value", bus_rdata, 8'h33);
        do_read(12'h400, v); check("R12 new value", v, 8'hA1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule